// File: doc/BRIEF.md
# SPI Memory Slave Command Front-End

This block is the serial side of a memory that hangs on an SPI bus as a slave. A fast system clock oversamples the bus pins: chip select, serial clock, serial data in and an active-low hold. The block turns the bit stream into parallel events for the memory core. The first byte after chip select goes low is taken as the command code. A valid code is announced with a one-cycle pulse. Every byte that follows is handed to the core with a strobe. At each byte boundary the block asks the core for the next byte to send back and shifts that byte out on the serial output. The serial output is presented as a data bit plus an output enable, for the pad ring to build the tri-state driver.

The block accepts both SPI modes in which data is taken on the rising clock edge, clock idle low and clock idle high. A command code outside a fixed legal set silences the interface until chip select next falls. Pulling hold low while the clock is low freezes the transfer exactly where it stands. The master can then move the clock and data lines freely, and the transfer resumes from the same bit once hold is released. The meaning of each command, the array and its timing belong to the core.

Top module: `spi_cmd_frontend`

## Requirements
- R1: Bits are taken MSB first on rising SCK edges. The first byte after chip-select fall is the command code. If it is one of the legal codes (default 0x06, 0x04, 0x05, 0x01, 0x03, 0x0B, 0x02, 0xD8), op_valid pulses high for exactly one clock and op_code carries the code.
- R2: After a valid code, each further received byte appears MSB first on rx_byte together with a one-clock rx_stb pulse.
- R3: After a valid code, every completed byte raises rd_req, which stays high until rd_ack. The byte given with rd_ack is shifted out MSB first during the next byte. It changes on falling SCK edges, with sdo_oe high while driving.
- R4: If the core has not acknowledged by the first falling edge of the next byte, that byte is sent as 0xFF.
- R5: Transfers behave the same whether SCK idles low (mode 0) or high (mode 3) when chip select falls.
- R6: After an invalid command code there is no op_valid, no rx_stb, no rd_req and sdo_oe stays low until chip select falls again. That next fall restarts the interface normally.
- R7: While chip select is high, SCK and SDI activity is ignored and sdo_oe is low. Raising chip select discards a partly received byte.
- R8: Hold taken while SCK is low drops sdo_oe and makes SCK edges have no effect. After release, the transfer continues at the same bit position.
- R9: After reset, sdo_oe, op_valid, rx_stb and rd_req are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select from the master, active low |
| sck | input | 1 | Serial clock from the master |
| sdi | input | 1 | Serial data into the slave |
| hold_n | input | 1 | Transfer pause, active low |
| sdo | output | 1 | Serial data out of the slave |
| sdo_oe | output | 1 | Output enable for sdo; low means high impedance |
| op_valid | output | 1 | One-clock pulse for a legal command code |
| op_code | output | 8 | Last legal command code |
| rx_stb | output | 1 | One-clock pulse for each byte after the code |
| rx_byte | output | 8 | Received byte, valid with rx_stb |
| rd_req | output | 1 | Request for the next byte to transmit |
| rd_ack | input | 1 | Core answer to rd_req |
| rd_data | input | 8 | Byte to transmit, taken with rd_ack |

## Verification
The hardest case to reach from the ports is a hold in the middle of a byte during which the master keeps toggling SCK and SDI. The bench asserts hold just after a falling edge, then toggles the clock and data several times. It releases hold only with the clock low. Correct bytes afterwards, in both directions, show that no bit was gained or lost. A second hard case is the handshake window. With the core model answering immediately, the bench checks the returned data. With the core model muted, the bench checks that 0xFF goes out. Invalid codes and partial bytes ended by chip select are each followed by a clean transaction, to show that recovery works.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

  // Transfer phase of the front-end
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_OPC  = 2'd1,
    PH_DATA = 2'd2,
    PH_LOCK = 2'd3
  } fe_phase_e;

  // One-cycle events derived from the oversampled bus pins
  typedef struct packed {
    logic rise;      // SCK rising, counted
    logic fall;      // SCK falling, counted
    logic sel_fall;  // chip select just went low
    logic desel;     // chip select is high
  } fe_evt_t;

  localparam int unsigned FE_BYTE_W = 8;

endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/spi_fe_pins.sv
module spi_fe_pins
  import spi_fe_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    s_sck,
  input  logic    s_cs_n,
  input  logic    s_hold_n,
  output fe_evt_t evt,
  output logic    hold_act
);

  logic sck_q, cs_q, hold_q;
  logic hold_d;

  // Hold only changes state while the serial clock is low
  always_comb begin
    hold_d = hold_q;
    if (!s_sck) hold_d = ~s_hold_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      cs_q   <= 1'b1;
      hold_q <= 1'b0;
    end else begin
      sck_q  <= s_sck;
      cs_q   <= s_cs_n;
      hold_q <= hold_d;
    end
  end

  // The previous clock level is tracked during hold, so release makes no edge
  always_comb begin
    evt.rise     = s_sck & ~sck_q & ~hold_q & ~s_cs_n;
    evt.fall     = ~s_sck & sck_q & ~hold_q & ~s_cs_n;
    evt.sel_fall = cs_q & ~s_cs_n;
    evt.desel    = s_cs_n;
  end

  assign hold_act = hold_q;

  // Hold is entered or left only with the clock low (R8)
  assert_hold_sck_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q != $past(hold_q)) |-> !$past(s_sck));

endmodule

// File: rtl/spi_fe_opmatch.sv
module spi_fe_opmatch #(
  parameter int unsigned N_OPS  = 8,
  parameter int unsigned BYTE_W = 8,
  parameter logic [N_OPS*BYTE_W-1:0] OP_LIST = '0
) (
  input  logic [BYTE_W-1:0] code,
  output logic              hit
);

  logic [N_OPS-1:0] match;

  for (genvar i = 0; i < int'(N_OPS); i++) begin : g_cmp
    assign match[i] = (code == OP_LIST[i*BYTE_W +: BYTE_W]);
  end

  assign hit = |match;

endmodule

// File: rtl/spi_fe_txpath.sv
module spi_fe_txpath #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         req_start,
  input  logic         shift_evt,
  input  logic         at_boundary,
  input  logic         rd_ack,
  input  logic [W-1:0] rd_data,
  output logic         rd_req,
  output logic         sdo,
  output logic         live
);

  logic         req_q, req_d;
  logic [W-1:0] buf_q, buf_d;
  logic [W-1:0] sh_q, sh_d;
  logic         live_q, live_d;

  always_comb begin
    req_d  = req_q;
    buf_d  = buf_q;
    sh_d   = sh_q;
    live_d = live_q;
    if (req_q && rd_ack) begin
      req_d = 1'b0;
      buf_d = rd_data;
    end
    if (req_start) begin
      req_d = 1'b1;
      buf_d = '1;            // stands if the core stays silent
    end
    if (shift_evt) begin
      if (at_boundary) begin
        sh_d   = buf_q;
        live_d = 1'b1;
      end else begin
        sh_d = {sh_q[W-2:0], 1'b1};
      end
    end
    if (clr) begin
      req_d  = 1'b0;
      live_d = 1'b0;
      sh_d   = '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      buf_q  <= '1;
      sh_q   <= '1;
      live_q <= 1'b0;
    end else begin
      req_q  <= req_d;
      buf_q  <= buf_d;
      sh_q   <= sh_d;
      live_q <= live_d;
    end
  end

  assign rd_req = req_q;
  assign sdo    = sh_q[W-1];
  assign live   = live_q;

  // A pending request is held until answered (R3)
  assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack && !clr) |=> rd_req);

  // An answer retires the request (R3)
  assert_req_retire_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_ack && !req_start) |=> !rd_req);

endmodule

// File: rtl/spi_cmd_frontend.sv
module spi_cmd_frontend
  import spi_fe_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned N_OPS       = 8,
  parameter logic [N_OPS*FE_BYTE_W-1:0] OP_LIST =
    {8'h06, 8'h04, 8'h05, 8'h01, 8'h03, 8'h0B, 8'h02, 8'hD8}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 sck,
  input  logic                 sdi,
  input  logic                 hold_n,
  output logic                 sdo,
  output logic                 sdo_oe,
  output logic                 op_valid,
  output logic [FE_BYTE_W-1:0] op_code,
  output logic                 rx_stb,
  output logic [FE_BYTE_W-1:0] rx_byte,
  output logic                 rd_req,
  input  logic                 rd_ack,
  input  logic [FE_BYTE_W-1:0] rd_data
);

  localparam int unsigned BW    = FE_BYTE_W;
  localparam int unsigned CNT_W = $clog2(BW);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BW - 1);

  // Pin synchronizers: {hold_n, sdi, sck, cs_n}
  logic [3:0] pins_s;
  logic       s_cs_n, s_sck, s_sdi, s_hold_n;

  spi_fe_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({hold_n, sdi, sck, cs_n}),
    .q     (pins_s)
  );

  assign {s_hold_n, s_sdi, s_sck, s_cs_n} = pins_s;

  fe_evt_t evt;
  logic    hold_act;

  spi_fe_pins u_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_sck    (s_sck),
    .s_cs_n   (s_cs_n),
    .s_hold_n (s_hold_n),
    .evt      (evt),
    .hold_act (hold_act)
  );

  // Receive sequencing
  fe_phase_e        phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [BW-2:0]    sh_q, sh_d;
  logic             opv_q, opv_d;
  logic [BW-1:0]    opc_q, opc_d;
  logic             rxs_q, rxs_d;
  logic [BW-1:0]    rxb_q, rxb_d;

  logic [BW-1:0] byte_full;
  logic          in_xfer, take, done, op_hit;
  logic          req_start, shift_evt, tx_live;

  assign byte_full = {sh_q, s_sdi};
  assign in_xfer   = (phase_q == PH_OPC) || (phase_q == PH_DATA);
  assign take      = evt.rise && in_xfer;
  assign done      = take && (cnt_q == LAST_BIT);

  spi_fe_opmatch #(.N_OPS(N_OPS), .BYTE_W(BW), .OP_LIST(OP_LIST)) u_match (
    .code (byte_full),
    .hit  (op_hit)
  );

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    opv_d   = 1'b0;
    opc_d   = opc_q;
    rxs_d   = 1'b0;
    rxb_d   = rxb_q;
    if (take) begin
      sh_d  = byte_full[BW-2:0];
      cnt_d = (cnt_q == LAST_BIT) ? '0 : cnt_q + 1'b1;
    end
    if (done && phase_q == PH_OPC) begin
      if (op_hit) begin
        phase_d = PH_DATA;
        opv_d   = 1'b1;
        opc_d   = byte_full;
      end else begin
        phase_d = PH_LOCK;
      end
    end
    if (done && phase_q == PH_DATA) begin
      rxs_d = 1'b1;
      rxb_d = byte_full;
    end
    if (evt.sel_fall) begin
      phase_d = PH_OPC;
      cnt_d   = '0;
    end
    if (evt.desel) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      opv_q   <= 1'b0;
      opc_q   <= '0;
      rxs_q   <= 1'b0;
      rxb_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      opv_q   <= opv_d;
      opc_q   <= opc_d;
      rxs_q   <= rxs_d;
      rxb_q   <= rxb_d;
    end
  end

  // Transmit side: a request at each byte end, a load at the next falling edge
  assign req_start = done && (((phase_q == PH_OPC) && op_hit) || (phase_q == PH_DATA));
  assign shift_evt = evt.fall && (phase_q == PH_DATA);

  spi_fe_txpath #(.W(BW)) u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (evt.desel),
    .req_start   (req_start),
    .shift_evt   (shift_evt),
    .at_boundary (cnt_q == '0),
    .rd_ack      (rd_ack),
    .rd_data     (rd_data),
    .rd_req      (rd_req),
    .sdo         (sdo),
    .live        (tx_live)
  );

  assign sdo_oe   = tx_live && (phase_q == PH_DATA) && !hold_act;
  assign op_valid = opv_q;
  assign op_code  = opc_q;
  assign rx_stb   = rxs_q;
  assign rx_byte  = rxb_q;

  // Code announcement lasts one clock (R1)
  assert_opv_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> !op_valid);

  // Received bytes only flow after a legal code (R2)
  assert_rx_in_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stb |-> (phase_q == PH_DATA || phase_q == PH_IDLE));

  // A locked interface stays silent (R6)
  assert_lock_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_LOCK) |-> (!rd_req && !sdo_oe));

  // Deselect clears the bit position and the driver (R7)
  assert_desel_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt.desel |=> (cnt_q == '0 && !sdo_oe && !rd_req));

  // The bit position is frozen during hold (R8)
  assert_hold_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hold_act && !evt.desel && !evt.sel_fall) |-> $stable(cnt_q));

endmodule

// File: tb/tb_spi_cmd_frontend.sv
`timescale 1ns/1ps
module tb_spi_cmd_frontend;

  localparam int HALF = 8;   // SCK half period in system clocks

  logic clk = 1'b0;
  logic rst_n;
  logic cs_n, sck, sdi, hold_n;
  logic sdo, sdo_oe, op_valid, rx_stb, rd_req, rd_ack;
  logic [7:0] op_code, rx_byte, rd_data;

  always #2.5 clk = ~clk;

  spi_cmd_frontend dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi), .hold_n(hold_n),
    .sdo(sdo), .sdo_oe(sdo_oe), .op_valid(op_valid), .op_code(op_code),
    .rx_stb(rx_stb), .rx_byte(rx_byte), .rd_req(rd_req), .rd_ack(rd_ack),
    .rd_data(rd_data)
  );

  int checks = 0;
  int fails  = 0;

  logic [7:0] exp_op[$];
  logic [7:0] exp_rx[$];
  logic [7:0] supplied[$];
  bit   core_mute = 0;
  bit   oe_seen, req_seen;
  int   cs_hi = 0;
  logic [7:0] core_next = 8'h5C;
  bit   mode3 = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Core model: answers a request on the next falling system-clock edge
  initial begin
    rd_ack  = 1'b0;
    rd_data = 8'h00;
    forever begin
      @(negedge clk);
      if (rst_n && rd_req && !rd_ack && !core_mute) begin
        rd_data = core_next;
        rd_ack  = 1'b1;
        supplied.push_back(core_next);
        core_next = core_next * 8'd5 + 8'h3B;
      end else begin
        rd_ack = 1'b0;
      end
    end
  end

  // Per-clock comparison against the expected event queues
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (op_valid) begin
          if (exp_op.size() == 0) chk(0, "R6 unexpected op_valid", op_code, 0);
          else begin
            logic [7:0] e;
            e = exp_op.pop_front();
            chk(op_code == e, "R1 op_code", op_code, e);
          end
        end
        if (rx_stb) begin
          if (exp_rx.size() == 0) chk(0, "R6 unexpected rx_stb", rx_byte, 0);
          else begin
            logic [7:0] e;
            e = exp_rx.pop_front();
            chk(rx_byte == e, "R2 rx_byte", rx_byte, e);
          end
        end
        if (sdo_oe) oe_seen = 1;
        if (rd_req) req_seen = 1;
        if (cs_n) cs_hi++; else cs_hi = 0;
        if (cs_hi > 4 && sdo_oe) chk(0, "R7 sdo_oe while deselected", 1, 0);
      end
    end
  end

  task automatic spi_start(input bit m3);
    mode3 = m3;
    sck = m3;
    wclk(4);
    cs_n = 1'b0;
    wclk(4);
  endtask

  task automatic spi_stop();
    if (!mode3) sck = 1'b0;
    wclk(4);
    cs_n = 1'b1;
    wclk(8);
    supplied.delete();
  endtask

  // One bit: falling edge with new data, optional hold, then rising edge
  task automatic spi_bit(input bit b, input bit do_hold, output bit got, output bit oe);
    sck = 1'b0;
    sdi = b;
    if (do_hold) begin
      wclk(4);
      hold_n = 1'b0;
      wclk(6);
      chk(sdo_oe == 1'b0, "R8 sdo_oe during hold", sdo_oe, 0);
      for (int t = 0; t < 3; t++) begin
        sck = 1'b1; sdi = ~sdi; wclk(4);
        sck = 1'b0; wclk(4);
      end
      sdi = b;
      wclk(2);
      hold_n = 1'b1;
      wclk(6);
    end
    wclk(HALF);
    got = sdo;
    oe  = sdo_oe;
    sck = 1'b1;
    wclk(HALF);
  endtask

  task automatic spi_xbyte(input logic [7:0] b, input int hold_bit,
                           output logic [7:0] got, output bit oe_all);
    bit g, o;
    oe_all = 1;
    for (int i = 7; i >= 0; i--) begin
      spi_bit(b[i], (7 - i) == hold_bit, g, o);
      got[i] = g;
      oe_all &= o;
    end
  endtask

  // Whole transaction: code, then n data bytes; hold placed at (hb, hbit)
  task automatic txn(input string req, input bit m3, input logic [7:0] opc, input bit valid,
                     input int n, input logic [7:0] base, input int hb, input int hbit);
    logic [7:0] got, dat, e;
    bit oe_all;
    oe_seen = 0;
    req_seen = 0;
    if (valid) exp_op.push_back(opc);
    spi_start(m3);
    spi_xbyte(opc, (hb == 0) ? hbit : -1, got, oe_all);
    for (int k = 0; k < n; k++) begin
      dat = base + 8'(k * 8'h37);
      if (valid) exp_rx.push_back(dat);
      spi_xbyte(dat, (hb == k + 1) ? hbit : -1, got, oe_all);
      if (valid) begin
        if (core_mute) e = 8'hFF;
        else if (supplied.size() > 0) e = supplied.pop_front();
        else e = 8'h00;
        chk(oe_all && got == e, {req, core_mute ? " R4 blank byte" : " R3 sdo byte"},
            {oe_all, got}, {1'b1, e});
      end
    end
    spi_stop();
    chk(exp_op.size() == 0, {req, " R1 code events"}, exp_op.size(), 0);
    chk(exp_rx.size() == 0, {req, " R2 rx events"}, exp_rx.size(), 0);
    exp_op.delete();
    exp_rx.delete();
    if (!valid) begin
      chk(!oe_seen, "R6 sdo_oe after invalid code", oe_seen, 0);
      chk(!req_seen, "R6 rd_req after invalid code", req_seen, 0);
    end
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bit g, o;
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; sdi = 1'b0; hold_n = 1'b1;
    wclk(5);
    rst_n = 1'b1;
    wclk(5);
    // R9 reset state
    chk(sdo_oe == 0, "R9 sdo_oe", sdo_oe, 0);
    chk(op_valid == 0, "R9 op_valid", op_valid, 0);
    chk(rx_stb == 0, "R9 rx_stb", rx_stb, 0);
    chk(rd_req == 0, "R9 rd_req", rd_req, 0);

    // Mode 0 read with data both ways
    txn("R1 mode0", 0, 8'h03, 1, 3, 8'hA5, -1, -1);
    // R5 mode 3, another legal code
    txn("R5 mode3", 1, 8'h0B, 1, 3, 8'h19, -1, -1);

    // R6 invalid codes lock, then a new select recovers
    txn("R6 invalid", 0, 8'h5A, 0, 2, 8'h03, -1, -1);
    txn("R6 invalid m3", 1, 8'hFF, 0, 1, 8'h06, -1, -1);
    txn("R6 recover", 0, 8'h02, 1, 2, 8'h81, -1, -1);

    // R7 activity while deselected
    oe_seen = 0;
    for (int i = 0; i < 12; i++) begin
      sdi = i[0];
      sck = 1'b1; wclk(HALF);
      sck = 1'b0; wclk(HALF);
    end
    chk(exp_op.size() == 0 && !oe_seen, "R7 deselected activity", oe_seen, 0);
    // R7 partial byte discarded by chip select
    spi_start(0);
    for (int i = 0; i < 5; i++) spi_bit(1'b1, 0, g, o);
    spi_stop();
    txn("R7 after partial", 0, 8'h05, 1, 1, 8'h4E, -1, -1);

    // R8 hold in the code byte and in data bytes, both modes
    txn("R8 hold opc", 0, 8'h03, 1, 2, 8'h6D, 0, 3);
    txn("R8 hold data", 0, 8'h03, 1, 3, 8'hC2, 2, 5);
    txn("R8 hold m3", 1, 8'hD8, 1, 2, 8'h11, 1, 0);

    // R4 silent core
    core_mute = 1;
    txn("R4 mute", 0, 8'h03, 1, 2, 8'h77, -1, -1);
    core_mute = 0;
    txn("R3 after mute", 1, 8'h01, 1, 2, 8'h3C, -1, -1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule